// File: doc/BRIEF.md
# Reduced-Width Floating-Point Adder

This block adds two floating-point operands held in a compact binary format whose exponent and fraction widths are independent parameters. The encoding keeps the familiar single-precision arrangement shrunk to fewer bits: a sign bit on top, a biased exponent field below it, and a fraction with an implied leading one at the bottom. The default build is the 16-bit format with a 6-bit exponent and a 9-bit fraction. The 32/24/20/12-bit formats are obtained by setting the parameters to (8,23), (6,17), (6,13) and (6,5).

A caller presents two operands together with a valid flag on any cycle, back to back if it wishes. Each result leaves a five-stage pipeline with its own valid flag. The stages are: magnitude ordering; alignment of the smaller significand with guard, round and sticky bits; signed add; leading-zero count with normalisation shift; exponent fix-up and packing. Results are truncated toward zero. Operands with a zero exponent field count as zero. Results too small for the format become zero, and results too large saturate.

Top module: `rfp_adder`

## Requirements
- R1: A word is laid out as sign at bit EXP_W+FRAC_W, exponent field in the next EXP_W bits down, and fraction in the low FRAC_W bits. The value is (-1)^sign x 1.fraction x 2^(exponent-(2^(EXP_W-1)-1)). In the default format, 1.0 is 16'h3E00.
- R2: out_valid is high on exactly the cycle five rising edges after in_valid was sampled high, and low otherwise. A new operand pair is accepted on every cycle.
- R3: When the operands have equal signs, the result is their exact sum truncated toward zero to FRAC_W fraction bits, carrying their sign.
- R4: When the operands have opposite signs, the result is the exact difference truncated toward zero in magnitude, carrying the sign of the larger-magnitude operand. This includes cancellations that remove many leading bits.
- R5: An input whose exponent field is 0 is treated as zero, whatever its fraction bits hold.
- R6: An exact zero sum, from equal magnitudes of opposite sign or from two zero inputs, is output as all bits zero (+0).
- R7: A non-zero exact sum whose normalised exponent field would be 0 or below is output as zero with the result's sign kept (sign bit, then all zero bits).
- R8: A sum whose normalised exponent field would exceed 2^EXP_W-1 saturates to the result's sign with exponent and fraction fields all ones.
- R9: While rst_n is low and after its release, out_valid is 0 and sum_out is 0 until a result arrives.
- R10: Swapping the two operands does not change the result.
- R11: An operand whose exponent is far below the other's is still counted through a sticky bit. Adding it leaves the larger value unchanged, and subtracting it gives the larger value's magnitude minus one unit in the last place.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand pair present this cycle |
| a_in | input | 1+EXP_W+FRAC_W | First operand |
| b_in | input | 1+EXP_W+FRAC_W | Second operand |
| out_valid | output | 1 | Result present this cycle |
| sum_out | output | 1+EXP_W+FRAC_W | Truncated sum |

## Verification
The bench targets the cases where a truncating adder usually goes wrong.

- Subtracting a tiny operand from 1.0 must give the all-ones fraction one exponent lower. A design that drops the sticky bit would return 1.0 unchanged.
- Heavy cancellation must renormalise by many places. A wrong leading-zero count shows up there as a wrong exponent.
- Exact cancellation must give +0, and a tiny negative difference must give -0. A design that mixes these up shows the wrong sign bit.
- Overflow must pin to the all-ones magnitude rather than wrap the exponent.
- A zero-exponent operand with fraction bits set must act as zero; a design that kept its fraction would change the sum.
- Every vector is also applied with its operands swapped, which exposes an ordering stage that picks the wrong operand as larger.

// File: rtl/rfp_pkg.sv
package rfp_pkg;
   // extra low-order bits kept during alignment: guard, round, sticky
   localparam int unsigned GRS_BITS = 3;
   // pipeline register stages from operand capture to result
   localparam int unsigned PIPE_STAGES = 5;

   function automatic int unsigned bias_of(input int unsigned ew);
      return (1 << (ew - 1)) - 1;
   endfunction
endpackage

// File: rtl/rfp_order.sv
// Stage-1 logic: unpack both operands, flush zero-exponent inputs, and
// route the larger magnitude to the "big" side.
module rfp_order #(
   parameter int unsigned EXP_W  = 6,
   parameter int unsigned FRAC_W = 9,
   localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W,
   localparam int unsigned MANT_W = FRAC_W + 1
) (
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   output logic              res_sign,
   output logic              eff_sub,
   output logic [EXP_W-1:0]  exp_big,
   output logic [EXP_W-1:0]  exp_gap,
   output logic [MANT_W-1:0] mant_big,
   output logic [MANT_W-1:0] mant_small
);
   logic [EXP_W-1:0]        ea, eb;
   logic                    za, zb;
   logic [MANT_W-1:0]       ma, mb;
   logic [EXP_W+FRAC_W-1:0] key_a, key_b;
   logic                    a_big;

   always_comb begin
      ea    = op_a[FRAC_W +: EXP_W];
      eb    = op_b[FRAC_W +: EXP_W];
      za    = (ea == '0);
      zb    = (eb == '0);
      ma    = za ? '0 : {1'b1, op_a[FRAC_W-1:0]};
      mb    = zb ? '0 : {1'b1, op_b[FRAC_W-1:0]};
      key_a = {ea, (za ? {FRAC_W{1'b0}} : op_a[FRAC_W-1:0])};
      key_b = {eb, (zb ? {FRAC_W{1'b0}} : op_b[FRAC_W-1:0])};
      a_big = (key_a >= key_b);

      eff_sub    = op_a[WORD_W-1] ^ op_b[WORD_W-1];
      res_sign   = a_big ? op_a[WORD_W-1] : op_b[WORD_W-1];
      exp_big    = a_big ? ea : eb;
      exp_gap    = a_big ? (ea - eb) : (eb - ea);
      mant_big   = a_big ? ma : mb;
      mant_small = a_big ? mb : ma;
   end
endmodule

// File: rtl/rfp_align.sv
// Stage-2 logic: shift the smaller significand right by the exponent gap,
// keeping guard and round bits and folding every lost bit into a sticky LSB.
module rfp_align #(
   parameter int unsigned EXP_W  = 6,
   parameter int unsigned MANT_W = 10,
   localparam int unsigned EXT_W = MANT_W + rfp_pkg::GRS_BITS
) (
   input  logic [MANT_W-1:0] mant_in,
   input  logic [EXP_W-1:0]  gap,
   output logic [EXT_W-1:0]  mant_out
);
   logic [EXT_W-1:0]   ext;
   logic [2*EXT_W-1:0] wide;
   logic [EXT_W-1:0]   kept, lost;
   logic               sticky;

   always_comb begin
      ext = {mant_in, {rfp_pkg::GRS_BITS{1'b0}}};
      if (32'(gap) >= EXT_W) wide = {{EXT_W{1'b0}}, ext};
      else                   wide = {ext, {EXT_W{1'b0}}} >> gap;
      kept     = wide[2*EXT_W-1:EXT_W];
      lost     = wide[EXT_W-1:0];
      sticky   = |lost;
      mant_out = {kept[EXT_W-1:1], kept[0] | sticky};
   end
endmodule

// File: rtl/rfp_lzc.sv
// Leading-zero counter built from a generated prefix-OR chain.
module rfp_lzc #(
   parameter int unsigned N = 14,
   localparam int unsigned CNT_W = $clog2(N + 1)
) (
   input  logic [N-1:0]     vec,
   output logic [CNT_W-1:0] count,
   output logic             all_zero
);
   logic [N-1:0] seen;

   assign seen[N-1] = vec[N-1];
   for (genvar i = N - 2; i >= 0; i--) begin : g_chain
      assign seen[i] = seen[i+1] | vec[i];
   end

   always_comb begin
      count = '0;
      for (int k = 0; k < N; k++) begin
         if (!seen[k]) count = count + CNT_W'(1);
      end
      all_zero = ~seen[0];
   end
endmodule

// File: rtl/rfp_adder.sv
module rfp_adder #(
   parameter int unsigned EXP_W  = 6,
   parameter int unsigned FRAC_W = 9,
   localparam int unsigned WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [WORD_W-1:0] a_in,
   input  logic [WORD_W-1:0] b_in,
   output logic              out_valid,
   output logic [WORD_W-1:0] sum_out
);
   localparam int unsigned MANT_W = FRAC_W + 1;
   localparam int unsigned EXT_W  = MANT_W + rfp_pkg::GRS_BITS;
   localparam int unsigned SUM_W  = EXT_W + 1;
   localparam int unsigned LZ_W   = $clog2(SUM_W + 1);
   localparam int unsigned EA_W   = ((EXP_W > LZ_W) ? EXP_W : LZ_W) + 2;
   localparam logic signed [EA_W-1:0] EXP_TOP = EA_W'((1 << EXP_W) - 1);

   // elaboration-time parameter checks
   if (EXP_W < 3 || EXP_W > 11) begin : g_bad_exp
      $error("rfp_adder: EXP_W must lie in 3..11");
   end
   if (FRAC_W < 2 || FRAC_W > 52) begin : g_bad_frac
      $error("rfp_adder: FRAC_W must lie in 2..52");
   end

   // ---------------- stage 1: order operands ----------------
   logic              c1_sign, c1_sub;
   logic [EXP_W-1:0]  c1_exp, c1_gap;
   logic [MANT_W-1:0] c1_mbig, c1_msmall;

   rfp_order #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_order (
      .op_a(a_in), .op_b(b_in),
      .res_sign(c1_sign), .eff_sub(c1_sub),
      .exp_big(c1_exp), .exp_gap(c1_gap),
      .mant_big(c1_mbig), .mant_small(c1_msmall)
   );

   logic              v1, sign1, sub1;
   logic [EXP_W-1:0]  exp1, gap1;
   logic [MANT_W-1:0] mbig1, msmall1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v1 <= 1'b0; sign1 <= 1'b0; sub1 <= 1'b0;
         exp1 <= '0; gap1 <= '0; mbig1 <= '0; msmall1 <= '0;
      end else begin
         v1 <= in_valid; sign1 <= c1_sign; sub1 <= c1_sub;
         exp1 <= c1_exp; gap1 <= c1_gap; mbig1 <= c1_mbig; msmall1 <= c1_msmall;
      end
   end

   // ---------------- stage 2: align ----------------
   logic [EXT_W-1:0] c2_small;

   rfp_align #(.EXP_W(EXP_W), .MANT_W(MANT_W)) u_align (
      .mant_in(msmall1), .gap(gap1), .mant_out(c2_small)
   );

   logic             v2, sign2, sub2;
   logic [EXP_W-1:0] exp2;
   logic [EXT_W-1:0] big2, small2;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v2 <= 1'b0; sign2 <= 1'b0; sub2 <= 1'b0;
         exp2 <= '0; big2 <= '0; small2 <= '0;
      end else begin
         v2 <= v1; sign2 <= sign1; sub2 <= sub1; exp2 <= exp1;
         big2   <= {mbig1, {rfp_pkg::GRS_BITS{1'b0}}};
         small2 <= c2_small;
      end
   end

   // ---------------- stage 3: add / subtract ----------------
   logic [SUM_W-1:0] c3_sum;
   always_comb begin
      if (sub2) c3_sum = {1'b0, big2} - {1'b0, small2};
      else      c3_sum = {1'b0, big2} + {1'b0, small2};
   end

   logic             v3, sign3;
   logic [EXP_W-1:0] exp3;
   logic [SUM_W-1:0] sum3;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v3 <= 1'b0; sign3 <= 1'b0; exp3 <= '0; sum3 <= '0;
      end else begin
         v3 <= v2; sign3 <= sign2; exp3 <= exp2; sum3 <= c3_sum;
      end
   end

   // ---------------- stage 4: count zeros, normalise ----------------
   logic [LZ_W-1:0]         c4_lz;
   logic                    c4_zero;
   logic [SUM_W-1:0]        c4_norm;
   logic signed [EA_W-1:0]  c4_exp;

   rfp_lzc #(.N(SUM_W)) u_lzc (
      .vec(sum3), .count(c4_lz), .all_zero(c4_zero)
   );

   always_comb begin
      c4_norm = sum3 << c4_lz;
      c4_exp  = $signed(EA_W'(exp3)) + $signed(EA_W'(1)) - $signed(EA_W'(c4_lz));
   end

   logic                   v4, sign4, zero4;
   logic signed [EA_W-1:0] exp4;
   logic [SUM_W-1:0]       norm4;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v4 <= 1'b0; sign4 <= 1'b0; zero4 <= 1'b0; exp4 <= '0; norm4 <= '0;
      end else begin
         v4    <= v3;
         sign4 <= sign3 & ~c4_zero;   // exact zero is always +0
         zero4 <= c4_zero;
         exp4  <= c4_exp;
         norm4 <= c4_norm;
      end
   end

   // ---------------- stage 5: range fix-up and pack ----------------
   logic [WORD_W-1:0] c5_word;
   always_comb begin
      if (zero4 || exp4 <= $signed(EA_W'(0)))
         c5_word = {sign4, {(WORD_W-1){1'b0}}};
      else if (exp4 > EXP_TOP)
         c5_word = {sign4, {(WORD_W-1){1'b1}}};
      else
         c5_word = {sign4, exp4[EXP_W-1:0], norm4[SUM_W-2 -: FRAC_W]};
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0; sum_out <= '0;
      end else begin
         out_valid <= v4; sum_out <= c5_word;
      end
   end

   // ---------------- assertions ----------------
   logic [2:0] since_rst;
   always_ff @(posedge clk) begin
      if (!rst_n)                 since_rst <= '0;
      else if (since_rst < 3'd5)  since_rst <= since_rst + 3'd1;
   end

   assert_valid_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst == 3'd5) |-> (out_valid == $past(in_valid, 5)));

   assert_sub_nonneg_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (v2 && sub2) |-> (big2 >= small2));

   assert_norm_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (v4 && !zero4) |-> norm4[SUM_W-1]);

   assert_zero_field_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && sum_out[FRAC_W +: EXP_W] == '0) |-> (sum_out[FRAC_W-1:0] == '0));

   assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst < 3'd5) |-> !out_valid);
endmodule

// File: tb/rfp_adder_test.sv
module rfp_adder_test;
   localparam int CLK_PERIOD = 10;
   localparam int EW = 6;
   localparam int FW = 9;
   localparam int WW = 1 + EW + FW;
   localparam int BIAS = (1 << (EW - 1)) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0;
   logic [WW-1:0] a_in = '0, b_in = '0;
   logic          out_valid;
   logic [WW-1:0] sum_out;

   int checks = 0, failures = 0, cyc = 0;
   logic [WW-1:0] exp_q [0:127];
   int            due_q [0:127];
   int            req_q [0:127];
   int            wr = 0, rd = 0;

   rfp_adder #(.EXP_W(EW), .FRAC_W(FW)) uut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
      .a_in(a_in), .b_in(b_in), .out_valid(out_valid), .sum_out(sum_out)
   );

   always #(CLK_PERIOD/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   // exact reference: scale both significands to a common integer grid
   function automatic logic [WW-1:0] model(input logic [WW-1:0] a, input logic [WW-1:0] b);
      logic [127:0] xa, xb, x;
      logic         s;
      int           p, e;
      logic [127:0] sh;
      int ea, eb;
      ea = int'(a[FW +: EW]);
      eb = int'(b[FW +: EW]);
      xa = (ea == 0) ? 128'd0 : (128'({1'b1, a[FW-1:0]}) << ea);
      xb = (eb == 0) ? 128'd0 : (128'({1'b1, b[FW-1:0]}) << eb);
      if (a[WW-1] == b[WW-1]) begin x = xa + xb; s = a[WW-1]; end
      else if (xa >= xb)      begin x = xa - xb; s = a[WW-1]; end
      else                    begin x = xb - xa; s = b[WW-1]; end
      if (x == 0) return '0;
      p = 0;
      for (int i = 0; i < 128; i++) if (x[i]) p = i;
      e = p - FW;
      if (e <= 0) return {s, {(WW-1){1'b0}}};
      if (e > (1 << EW) - 1) return {s, {(WW-1){1'b1}}};
      sh = x >> (p - FW);
      return {s, e[EW-1:0], sh[FW-1:0]};
   endfunction

   task automatic send(input logic [WW-1:0] a, input logic [WW-1:0] b,
                       input logic [WW-1:0] expv, input int rq);
      @(negedge clk);
      a_in = a; b_in = b; in_valid = 1'b1;
      exp_q[wr] = expv; due_q[wr] = cyc + 5; req_q[wr] = rq;
      wr++;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         in_valid = 1'b0; a_in = '0; b_in = '0;
      end
   endtask

   // scoreboard: every result must arrive with the right value on its due cycle (R2)
   always @(negedge clk) begin
      if (rst_n && out_valid) begin
         checks++;
         if (rd >= wr) begin
            failures++;
            $display("FAIL R2 unexpected out_valid at cycle %0d: actual sum=%h expected no result", cyc, sum_out);
         end else begin
            if (cyc != due_q[rd] || sum_out !== exp_q[rd]) begin
               failures++;
               $display("FAIL R%0d vec %0d: actual %h at cycle %0d, expected %h at cycle %0d",
                        req_q[rd], rd, sum_out, cyc, exp_q[rd], due_q[rd]);
            end
            rd++;
         end
      end
   end

   // {requirement, a, b}
   localparam int NV = 16;
   localparam logic [39:0] VEC [NV] = '{
      {8'd3,  16'h3E00, 16'h3E00},   // R3 1+1
      {8'd3,  16'h4A35, 16'h3C9B},   // R3 mixed exponents
      {8'd3,  16'hC123, 16'hC456},   // R3 negative pair
      {8'd4,  16'h3F00, 16'hBE00},   // R4 1.5-1
      {8'd4,  16'h3E01, 16'hBE00},   // R4 deep cancellation
      {8'd4,  16'h5555, 16'hD2AA},   // R4 sign of larger
      {8'd4,  16'hC123, 16'h4456},   // R4 negative smaller
      {8'd5,  16'h01FF, 16'h3E00},   // R5 zero-exponent operand
      {8'd6,  16'h3E00, 16'hBE00},   // R6 exact cancel
      {8'd6,  16'h8000, 16'h8000},   // R6 -0 + -0
      {8'd7,  16'h03FE, 16'h83FF},   // R7 tiny negative difference
      {8'd7,  16'h03FF, 16'h83FE},   // R7 tiny positive difference
      {8'd8,  16'h7FFF, 16'h7FFF},   // R8 overflow positive
      {8'd8,  16'hFE00, 16'hFC00},   // R8 overflow negative
      {8'd11, 16'h3E00, 16'h0401},   // R11 far small add
      {8'd11, 16'h3E00, 16'h8401}    // R11 far small subtract
   };

   initial begin
      // R9: reset state
      idle(3);
      checks++;
      if (out_valid !== 1'b0 || sum_out !== '0) begin
         failures++;
         $display("FAIL R9 reset: actual valid=%b sum=%h expected valid=0 sum=0000", out_valid, sum_out);
      end
      @(negedge clk); rst_n = 1'b1;
      idle(6);
      checks++;
      if (out_valid !== 1'b0 || sum_out !== '0) begin
         failures++;
         $display("FAIL R9 after release: actual valid=%b sum=%h expected valid=0 sum=0000", out_valid, sum_out);
      end

      // R1: format literals, R2: isolated latency
      send(16'h3E00, 16'h3E00, 16'h4000, 1); idle(7);  // R1 1+1=2
      send(16'h3F00, 16'h4000, 16'h4180, 1); idle(7);  // R1 1.5+2=3.5
      send(16'h3E00, 16'hBF00, 16'hBC00, 2); idle(7);  // R2 1-1.5=-0.5

      // table, issued back to back (R2 throughput), then swapped (R10)
      for (int i = 0; i < NV; i++)
         send(VEC[i][31:16], VEC[i][15:0], model(VEC[i][31:16], VEC[i][15:0]), int'(VEC[i][39:32]));
      for (int i = 0; i < NV; i++)
         send(VEC[i][15:0], VEC[i][31:16], model(VEC[i][31:16], VEC[i][15:0]), 10); // R10
      idle(8);

      // R11 and R7 literal expectations independent of the model
      send(16'h3E00, 16'h8401, 16'h3DFF, 11); idle(2);  // R11 1-tiny = 0.111..1
      send(16'h03FE, 16'h83FF, 16'h8000, 7);  idle(2);  // R7 signed zero
      send(16'h7FFF, 16'h7E00, 16'h7FFF, 8);  idle(8);  // R8 saturate

      checks++;
      if (rd != wr) begin
         failures++;
         $display("FAIL R2 missing results: actual %0d expected %0d", rd, wr);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      wait (cyc > 20000);
      failures++;
      $display("FAIL watchdog: actual cycle %0d expected completion", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule